// File: doc/BRIEF.md
# Execute Unit with Condition Flags and Branch Test

This block is the arithmetic stage of a small 32-bit teaching processor. Each cycle it takes two operands and a four-bit operation code and produces a result word `valE` without delay: a sum, a difference (the second operand minus the first), a bitwise AND or a bitwise XOR.

Three stored flags sit beside the arithmetic: zero, negative and signed overflow. They are written on the clock edge only when an arithmetic or logic instruction asks for it. Moves, jumps, stack traffic, calls and returns leave them alone.

A condition decoder reads the stored flags and answers one of seven tests. The same code serves jumps and conditional moves. The stack-pointer step reuses the adder: an override input forces an add and blocks any flag write. The caller supplies +4 to pop or −4 to push as the first operand.

Top module: `exec_unit`

## Requirements
- R1: With `addOverride` low and `aluFn` = 0, `valE` equals `valB + valA` modulo 2^32, in the same cycle.
- R2: With `addOverride` low and `aluFn` = 1, `valE` equals `valB − valA` modulo 2^32 (first operand subtracted from the second).
- R3: With `addOverride` low, `aluFn` = 2 gives `valE = valA & valB` and `aluFn` = 3 gives `valE = valA ^ valB`.
- R4: At a rising clock edge where `setCc` is high, `addOverride` is low and `aluFn` is 0 to 3, the flags take the result of that cycle: `zf` = (result is zero), `sf` = result bit 31.
- R5: The stored overflow flag is set for add when both operands share a sign and the result's sign differs from it. It is set for subtract when the operands' signs differ and the result's sign differs from `valB`. It is cleared for AND and XOR.
- R6: The flags keep their value at any edge where `setCc` is low, `addOverride` is high, or `aluFn` is above 3.
- R7: After reset, `zf` = 1, `sf` = 0 and `of` = 0.
- R8: `condTrue` follows the stored flags through `condFn`, with lt = `sf ^ of`:
  - 0 is always true.
  - 1 gives lt | zf.
  - 2 gives lt.
  - 3 gives zf.
  - 4 gives !zf.
  - 5 gives !lt.
  - 6 gives !lt & !zf.
- R9: `condFn` values 7 to 15 give `condTrue` = 0.
- R10: With `addOverride` high, `valE` equals `valB + valA` whatever `aluFn` holds. So `valA` = 4 steps a stack pointer up and `valA` = 0xFFFFFFFC steps it down.
- R11: With `addOverride` low and `aluFn` above 3, `valE` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the flags update on its rising edge |
| rstN | input | 1 | Active-low asynchronous reset of the flags |
| aluFn | input | 4 | Operation: 0 add, 1 subtract, 2 AND, 3 XOR |
| valA | input | 32 | First operand (register A, or the stack step) |
| valB | input | 32 | Second operand (register B, or the stack pointer) |
| setCc | input | 1 | Request to store the flags of this operation |
| addOverride | input | 1 | Forces an add and suppresses flag writes |
| condFn | input | 4 | Condition code to evaluate, 0 to 6 |
| valE | output | 32 | Result word |
| zf | output | 1 | Stored zero flag |
| sf | output | 1 | Stored negative flag |
| of | output | 1 | Stored signed-overflow flag |
| condTrue | output | 1 | Selected condition holds on the stored flags |

## Verification
The bench uses random operands, random operation codes, and random settings of the set-flags and override inputs. This mix separates a flag that follows every cycle from one that follows only real arithmetic or logic operations.

Directed cases cover the rest:
- 0x7FFFFFFF+1 and 0x80000000−1 tell a correct overflow rule from one that reads the wrong operand's sign.
- Small unequal operands subtracted in both orders catch a swapped subtraction.
- Zero results and push/pop steps round out the set.

After every operation all sixteen condition codes are swept against the stored flags. That reveals a wrong formula or a missing guard on codes above six.

// File: rtl/exu_pkg.sv
package exu_pkg;
  localparam logic [3:0] FN_ADD = 4'd0;
  localparam logic [3:0] FN_SUB = 4'd1;
  localparam logic [3:0] FN_AND = 4'd2;
  localparam logic [3:0] FN_XOR = 4'd3;

  typedef enum logic [3:0] {
    COND_ALWAYS = 4'd0,
    COND_LE     = 4'd1,
    COND_LT     = 4'd2,
    COND_EQ     = 4'd3,
    COND_NE     = 4'd4,
    COND_GE     = 4'd5,
    COND_GT     = 4'd6
  } cond_e;

  // One-hot operation strobes plus a flag-load strobe, control -> datapath
  typedef struct packed {
    logic useAdd;
    logic useSub;
    logic useAnd;
    logic useXor;
    logic loadFlags;
  } exu_strobe_t;
endpackage

// File: rtl/exu_ctrl.sv
module exu_ctrl
  import exu_pkg::*;
(
  input  logic [3:0]  aluFn,
  input  logic        setCc,
  input  logic        addOverride,
  output exu_strobe_t strobe
);
  logic fnValid;

  assign fnValid = (aluFn <= FN_XOR);

  always_comb begin
    strobe = '0;
    if (addOverride) begin
      strobe.useAdd = 1'b1;
    end else begin
      unique case (aluFn)
        FN_ADD:  strobe.useAdd = 1'b1;
        FN_SUB:  strobe.useSub = 1'b1;
        FN_AND:  strobe.useAnd = 1'b1;
        FN_XOR:  strobe.useXor = 1'b1;
        default: ;
      endcase
    end
    strobe.loadFlags = setCc && !addOverride && fnValid;
  end
endmodule

// File: rtl/exu_cond.sv
module exu_cond
  import exu_pkg::*;
(
  input  logic       zfQ,
  input  logic       sfQ,
  input  logic       ofQ,
  input  logic [3:0] condFn,
  output logic       condTrue
);
  logic lessThan;

  assign lessThan = sfQ ^ ofQ;

  always_comb begin
    unique case (condFn)
      COND_ALWAYS: condTrue = 1'b1;
      COND_LE:     condTrue = lessThan | zfQ;
      COND_LT:     condTrue = lessThan;
      COND_EQ:     condTrue = zfQ;
      COND_NE:     condTrue = !zfQ;
      COND_GE:     condTrue = !lessThan;
      COND_GT:     condTrue = !lessThan && !zfQ;
      default:     condTrue = 1'b0;
    endcase
  end
endmodule

// File: rtl/exu_datapath.sv
module exu_datapath
  import exu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  exu_strobe_t  strobe,
  input  logic [W-1:0] valA,
  input  logic [W-1:0] valB,
  input  logic [3:0]   condFn,
  output logic [W-1:0] valE,
  output logic         zfQ,
  output logic         sfQ,
  output logic         ofQ,
  output logic         condTrue
);
  localparam int MSB = W - 1;

  logic [W-1:0] sumVal;
  logic [W-1:0] diffVal;
  logic         ovAdd;
  logic         ovSub;
  logic         ofNext;

  assign sumVal  = valB + valA;
  assign diffVal = valB - valA;

  assign ovAdd = (valA[MSB] == valB[MSB]) && (sumVal[MSB] != valA[MSB]);
  assign ovSub = (valA[MSB] != valB[MSB]) && (diffVal[MSB] != valB[MSB]);

  always_comb begin
    valE = '0;
    if (strobe.useAdd) valE = sumVal;
    if (strobe.useSub) valE = diffVal;
    if (strobe.useAnd) valE = valA & valB;
    if (strobe.useXor) valE = valA ^ valB;
  end

  assign ofNext = strobe.useAdd ? ovAdd : (strobe.useSub ? ovSub : 1'b0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      zfQ <= 1'b1;
      sfQ <= 1'b0;
      ofQ <= 1'b0;
    end else if (strobe.loadFlags) begin
      zfQ <= (valE == '0);
      sfQ <= valE[MSB];
      ofQ <= ofNext;
    end
  end

  exu_cond cond_i (
    .zfQ      (zfQ),
    .sfQ      (sfQ),
    .ofQ      (ofQ),
    .condFn   (condFn),
    .condTrue (condTrue)
  );
endmodule

// File: rtl/exec_unit.sv
module exec_unit
  import exu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [3:0]   aluFn,
  input  logic [W-1:0] valA,
  input  logic [W-1:0] valB,
  input  logic         setCc,
  input  logic         addOverride,
  input  logic [3:0]   condFn,
  output logic [W-1:0] valE,
  output logic         zf,
  output logic         sf,
  output logic         of,
  output logic         condTrue
);
  exu_strobe_t strobe;

  exu_ctrl ctrl_i (
    .aluFn       (aluFn),
    .setCc       (setCc),
    .addOverride (addOverride),
    .strobe      (strobe)
  );

  exu_datapath #(.W(W)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .valA     (valA),
    .valB     (valB),
    .condFn   (condFn),
    .valE     (valE),
    .zfQ      (zf),
    .sfQ      (sf),
    .ofQ      (of),
    .condTrue (condTrue)
  );
endmodule

// File: rtl/exu_checker.sv
module exu_checker #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rstN,
  input logic [3:0]   aluFn,
  input logic [W-1:0] valA,
  input logic [W-1:0] valB,
  input logic         setCc,
  input logic         addOverride,
  input logic [3:0]   condFn,
  input logic [W-1:0] valE,
  input logic         zf,
  input logic         sf,
  input logic         of,
  input logic         condTrue
);
  logic opWrite;
  assign opWrite = setCc && !addOverride && (aluFn < 4'd4);

  assert_flags_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !opWrite |=> $stable({zf, sf, of}));

  assert_zero_flag_R4: assert property (@(posedge clk) disable iff (!rstN)
    opWrite |=> (zf == ($past(valE) == '0)));

  assert_logic_clears_of_R5: assert property (@(posedge clk) disable iff (!rstN)
    (opWrite && aluFn[1]) |=> !of);

  assert_stack_add_R10: assert property (@(posedge clk) disable iff (!rstN)
    addOverride |-> (valE == valB + valA));

  assert_bad_cond_low_R9: assert property (@(posedge clk) disable iff (!rstN)
    (condFn > 4'd6) |-> !condTrue);

  assert_eq_cond_R8: assert property (@(posedge clk) disable iff (!rstN)
    (condFn == 4'd3) |-> (condTrue == zf));
endmodule

bind exec_unit exu_checker #(.W(W)) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .aluFn       (aluFn),
  .valA        (valA),
  .valB        (valB),
  .setCc       (setCc),
  .addOverride (addOverride),
  .condFn      (condFn),
  .valE        (valE),
  .zf          (zf),
  .sf          (sf),
  .of          (of),
  .condTrue    (condTrue)
);

// File: tb/exec_unit_tb.sv
module exec_unit_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  aluFn = '0;
  logic [31:0] valA = '0;
  logic [31:0] valB = '0;
  logic        setCc = 1'b0;
  logic        addOverride = 1'b0;
  logic [3:0]  condFn = '0;
  logic [31:0] valE;
  logic        zf, sf, of, condTrue;

  int testCount = 0;
  int failCount = 0;
  logic mZ = 1'b1, mS = 1'b0, mO = 1'b0;

  always #5 clk = ~clk;

  exec_unit dut_i (
    .clk(clk), .rstN(rstN), .aluFn(aluFn), .valA(valA), .valB(valB),
    .setCc(setCc), .addOverride(addOverride), .condFn(condFn),
    .valE(valE), .zf(zf), .sf(sf), .of(of), .condTrue(condTrue)
  );

  function automatic logic [31:0] refVal(logic [3:0] fn, logic [31:0] a, logic [31:0] b, logic ovr);
    if (ovr) return b + a;
    case (fn)
      4'd0: return b + a;
      4'd1: return b - a;
      4'd2: return a & b;
      4'd3: return a ^ b;
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic refOf(logic [3:0] fn, logic [31:0] a, logic [31:0] b);
    logic [31:0] r;
    r = refVal(fn, a, b, 1'b0);
    if (fn == 4'd0) return (a[31] == b[31]) && (r[31] != a[31]);
    if (fn == 4'd1) return (a[31] != b[31]) && (r[31] != b[31]);
    return 1'b0;
  endfunction

  function automatic logic refCond(logic [3:0] c, logic z, logic s, logic o);
    logic lt;
    lt = s ^ o;
    case (c)
      4'd0: return 1'b1;
      4'd1: return lt | z;
      4'd2: return lt;
      4'd3: return z;
      4'd4: return !z;
      4'd5: return !lt;
      4'd6: return !lt && !z;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic checkFlags(string req);
    check(req, {29'd0, zf, sf, of}, {29'd0, mZ, mS, mO});
  endtask

  task automatic sweepConds();
    for (int c = 0; c < 16; c++) begin
      condFn = c[3:0];
      #1;
      if (c <= 6) check("R8 cond", {31'd0, condTrue}, {31'd0, refCond(c[3:0], mZ, mS, mO)});
      else        check("R9 cond>6", {31'd0, condTrue}, 32'd0);
    end
  endtask

  // Drive one operation, check valE, clock it, check flags and conditions
  task automatic runOp(logic [3:0] fn, logic [31:0] a, logic [31:0] b, logic sc, logic ovr);
    logic [31:0] e;
    string rq;
    @(negedge clk);
    aluFn = fn; valA = a; valB = b; setCc = sc; addOverride = ovr;
    #1;
    e = refVal(fn, a, b, ovr);
    if (ovr) rq = "R10 override";
    else if (fn == 4'd0) rq = "R1 add";
    else if (fn == 4'd1) rq = "R2 sub";
    else if (fn <= 4'd3) rq = "R3 logic";
    else rq = "R11 bad fn";
    check(rq, valE, e);
    @(posedge clk);
    #1;
    if (sc && !ovr && fn <= 4'd3) begin
      mZ = (e == 32'd0); mS = e[31]; mO = refOf(fn, a, b);
      checkFlags("R4/R5 flag update");
    end else begin
      checkFlags("R6 flags hold");
    end
    setCc = 1'b0;
    sweepConds();
  endtask

  initial begin
    #2_000_000;
    failCount++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    int unsigned seedDummy;
    seedDummy = $urandom(32'd20240611);
    #12;
    checkFlags("R7 reset");
    sweepConds();
    rstN = 1'b1;
    // directed corners
    runOp(4'd0, 32'h0000_0001, 32'h7FFF_FFFF, 1'b1, 1'b0); // R5 add overflow
    runOp(4'd1, 32'h0000_0001, 32'h8000_0000, 1'b1, 1'b0); // R5 sub overflow
    runOp(4'd1, 32'h0000_0003, 32'h0000_0005, 1'b1, 1'b0); // R2 order 5-3
    runOp(4'd1, 32'h0000_0005, 32'h0000_0003, 1'b1, 1'b0); // R2 order 3-5
    runOp(4'd3, 32'hA5A5_5A5A, 32'hA5A5_5A5A, 1'b1, 1'b0); // zero result
    runOp(4'd2, 32'hF000_0000, 32'h8000_00FF, 1'b1, 1'b0); // R3 and negative
    runOp(4'd0, 32'h0000_0004, 32'h0000_1000, 1'b1, 1'b1); // R10 pop, R6
    runOp(4'd1, 32'hFFFF_FFFC, 32'h0000_1000, 1'b1, 1'b1); // R10 push despite fn
    runOp(4'd9, 32'h1234_5678, 32'h1111_1111, 1'b1, 1'b0); // R11, R6
    runOp(4'd0, 32'h8000_0000, 32'h8000_0000, 1'b0, 1'b0); // R6 setCc low
    runOp(4'd0, 32'h8000_0000, 32'h8000_0000, 1'b1, 1'b0); // add neg overflow to zero
    // constrained random
    for (int i = 0; i < 400; i++) begin
      logic [3:0] f;
      logic [31:0] a, b;
      f = ($urandom % 8 == 0) ? 4'($urandom) : 4'($urandom % 4);
      a = $urandom; b = $urandom;
      if ($urandom % 4 == 0) a = b;
      runOp(f, a, b, ($urandom % 3) != 0, ($urandom % 6) == 0);
    end
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule